// File: doc/BRIEF.md
# Single-Bit Error Locator Sequencer

This block walks a fixed 256-bit message through an 8-bit serial polynomial divider, one bit per clock, and then stops. The message is held in a constant memory set by a parameter. A counter steps through the message positions, and that counter is also the memory read address. The last eight positions of the stream do not come from the memory. They come from an 8-bit switch pattern. Because of this, one run can produce the check bits of the message, and a later run can verify them.

A mode bit, captured while reset is held, chooses how the run ends and what the display shows.

- **Mode 1 (parity mode):** all 256 positions are shifted and the display shows the divider remainder.
  - With the switches at zero, the remainder is the message parity.
  - With that parity entered on the switches, the remainder is zero for an intact message. If one bit is corrupted, the remainder is the error syndrome.
- **Mode 0 (locate mode):** the run stops as soon as the divider state equals the switch pattern. The display then shows the position counter, which is the error position.

A two-state controller (running / finished) sequences the run. Once finished, it stays finished until the next reset.

Top module: `errloc_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after the internal reset is released, the counter and the divider hold zero. The display therefore reads 0x00 in both modes.
- R2: In mode 1 with the switches at 0x00, the final display is the remainder of the 256-bit stream divided by x^8+x^4+x^3+x^2+1. Message position p (0..247) is parameter bit p. The stream enters most significant first, so position 0 is the highest power of x.
- R3: In mode 1, when the parity obtained under R2 is placed on the switches, the final display is 0x00 for an uncorrupted message.
- R4: Stream positions 248..255 take switch bit (255 - position). Switch bit 7 enters first and switch bit 0 enters last.
- R5: In mode 0, the run stops in the first cycle in which the divider state equals the switches. The display then shows the number of bits already shifted. A switch value of 0x00 stops at once and displays 0x00.
- R6: In mode 0, if no match occurs, the run ends at terminal count after 256 shifts and the display shows 0xFF.
- R7: After the run has finished, the counter and the divider do not change. Changing the switches does not alter the display until the next reset.
- R8: The mode is sampled only while reset is applied. Changing the mode input during a run has no effect on that run.
- R9: When message bit e is inverted and the R3 parity is on the switches, mode 1 displays x^(255-e) mod x^8+x^4+x^3+x^2+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 1 = parity run over all positions, 0 = locate run that stops on match |
| sw_i | input | 8 | Switch pattern: tail message bits and comparison value |
| disp_o | output | 8 | Divider state in mode 1, position counter in mode 0 |

## Verification
A corrupted divider bit or a wrong tap spreads into every later state. It therefore shows up as a wrong final remainder in mode 1, but only once the run ends, about 258 cycles after reset. A corrupted counter or controller shows up as a wrong stop position in mode 0, or as a display that keeps moving after the finish. Switch and mode changes made after the finish show this directly. The R9 syndrome is predicted from the error position alone, not by running the stream. This makes it a separate cross-check of the divider taps and of the bit order of the stream.

// File: rtl/errloc_pkg.sv
package errloc_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DONE = 1'b1
  } run_state_t;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/errloc_ctl.sv
module errloc_ctl
  import errloc_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic mode_par,
  input  logic tc,
  input  logic match,
  output logic cnt_en,
  output logic div_en,
  output logic done
);

  run_state_t state_q, state_d;
  logic       hit;
  logic       stop;
  logic       running;

  assign running = (state_q == ST_RUN);
  assign hit     = ~mode_par & match;
  assign stop    = tc | hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (stop) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign cnt_en = running & ~stop;
  assign div_en = running & ~hit;
  assign done   = ~running;

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> done);

  p_tc_stop_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (running && tc) |=> done);

  p_match_stop_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (running && !mode_par && match) |=> done);

endmodule

// File: rtl/errloc_cnt.sv
module errloc_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  output logic [CW-1:0] q,
  output logic          tc
);

  logic [CW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = q + CW'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign tc = &q;

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/errloc_src.sv
module errloc_src #(
  parameter int unsigned          LEN  = 256,
  parameter int unsigned          SW_W = 8,
  parameter int unsigned          CW   = 8,
  parameter logic [LEN-1:0]       MSG  = '0
) (
  input  logic [CW-1:0]   addr,
  input  logic [SW_W-1:0] sw,
  output logic            bit_o
);

  localparam int unsigned TAIL = LEN - SW_W;
  localparam int unsigned IW   = (SW_W > 1) ? $clog2(SW_W) : 1;

  logic          in_tail;
  logic [CW-1:0] offs;
  logic [IW-1:0] sidx;

  assign in_tail = (addr >= CW'(TAIL));
  assign offs    = addr - CW'(TAIL);
  assign sidx    = IW'(SW_W - 1) - offs[IW-1:0];

  always_comb begin
    if (in_tail) bit_o = sw[sidx];
    else         bit_o = MSG[addr];
  end

endmodule

// File: rtl/errloc_div.sv
module errloc_div #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] TAPS = 8'h1D
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic         fb;
  logic [W-1:0] nxt;
  logic [W-1:0] q_d;

  assign fb = q[W-1];

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = din ^ (TAPS[i] & fb);
    end else begin : g_body
      assign nxt[i] = q[i-1] ^ (TAPS[i] & fb);
    end
  end

  always_comb begin
    q_d = q;
    if (en) q_d = nxt;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  p_div_hold_r7: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/errloc_seq.sv
module errloc_seq #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SYN_W = 8,
  parameter logic [SYN_W-1:0] POLY = 8'h1D,
  parameter logic [(1<<CNT_W)-1:0] MSG_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [SYN_W-1:0] sw_i,
  output logic [7:0]       disp_o
);

  localparam int unsigned MSG_LEN = 1 << CNT_W;
  localparam int unsigned DISP_W  = errloc_pkg::max_w(CNT_W, SYN_W);

  logic [1:0]       rs_q;
  logic             core_rst_n;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tc;
  logic [SYN_W-1:0] div_q;
  logic             ser_bit;
  logic             match;
  logic             cnt_en;
  logic             div_en;
  logic             done;
  logic [DISP_W-1:0] disp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  always_ff @(posedge clk) begin
    if (!core_rst_n) mode_q <= mode_i;
  end

  errloc_cnt #(.CW(CNT_W)) u_cnt (
    .clk    (clk),
    .arst_n (core_rst_n),
    .en     (cnt_en),
    .q      (cnt_q),
    .tc     (tc)
  );

  errloc_src #(
    .LEN  (MSG_LEN),
    .SW_W (SYN_W),
    .CW   (CNT_W),
    .MSG  (MSG_INIT)
  ) u_src (
    .addr  (cnt_q),
    .sw    (sw_i),
    .bit_o (ser_bit)
  );

  errloc_div #(.W(SYN_W), .TAPS(POLY)) u_div (
    .clk    (clk),
    .arst_n (core_rst_n),
    .en     (div_en),
    .din    (ser_bit),
    .q      (div_q)
  );

  assign match = (div_q == sw_i);

  errloc_ctl u_ctl (
    .clk      (clk),
    .arst_n   (core_rst_n),
    .mode_par (mode_q),
    .tc       (tc),
    .match    (match),
    .cnt_en   (cnt_en),
    .div_en   (div_en),
    .done     (done)
  );

  always_comb begin
    if (mode_q) disp_w = DISP_W'(div_q);
    else        disp_w = DISP_W'(cnt_q);
  end
  assign disp_o = 8'(disp_w);

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |=> (cnt_q == '0) && (div_q == '0));

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && done) |=> ($stable(cnt_q) && $stable(div_q)));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |=> $stable(mode_q));

  p_par_full_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode_q && !done && !tc) |=> !done);

endmodule

// File: tb/errloc_seq_tb.sv
module errloc_seq_tb;

  localparam logic [255:0] MSG = 256'h3C91_A7E2_5B08_F4D6_1E73_9A2C_C5B0_6D17_84F3_2A9E_E16B_07C5_D238_4F91_B6A0_5C7E;
  localparam int           ERR_POS = 37;
  localparam logic [255:0] MSG_ERR = MSG ^ (256'd1 << ERR_POS);
  localparam logic [7:0]   POLY = 8'h1D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b1;
  logic [7:0] sw_i = 8'h00;
  logic [7:0] disp_a;
  logic [7:0] disp_b;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string      req;
    int         dut;
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  event  sample_ev;

  always #5 clk = ~clk;

  errloc_seq #(.MSG_INIT(MSG)) u_dut (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .sw_i (sw_i), .disp_o (disp_a)
  );

  errloc_seq #(.MSG_INIT(MSG_ERR)) u_dut_err (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .sw_i (sw_i), .disp_o (disp_b)
  );

  function automatic logic [7:0] model(input logic [255:0] m, input bit md, input logic [7:0] s);
    logic [7:0] st;
    logic       b;
    st = 8'h00;
    for (int k = 0; k < 256; k++) begin
      if (!md && st == s) return 8'(k);
      b  = (k < 248) ? m[k] : s[255-k];
      st = {st[6:0], b} ^ (st[7] ? POLY : 8'h00);
    end
    return md ? st : 8'hFF;
  endfunction

  function automatic bit never_hits(input logic [255:0] m, input logic [7:0] s);
    logic [7:0] st;
    logic       b;
    st = 8'h00;
    for (int k = 0; k < 256; k++) begin
      if (st == s) return 1'b0;
      b  = (k < 248) ? m[k] : s[255-k];
      st = {st[6:0], b} ^ (st[7] ? POLY : 8'h00);
    end
    return 1'b1;
  endfunction

  function automatic logic [7:0] state_after(input logic [255:0] m, input int n);
    logic [7:0] st;
    st = 8'h00;
    for (int k = 0; k < n; k++) st = {st[6:0], m[k]} ^ (st[7] ? POLY : 8'h00);
    return st;
  endfunction

  task automatic expect_val(input string req, input int dut, input logic [7:0] e);
    item_t it;
    it.req = req;
    it.dut = dut;
    it.exp = e;
    sb.push_back(it);
  endtask

  task automatic sample();
    -> sample_ev;
    #1;
  endtask

  initial begin
    item_t      it;
    logic [7:0] act;
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        it  = sb.pop_front();
        act = (it.dut == 0) ? disp_a : disp_b;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: dut%0d display=%h expected=%h", it.req, it.dut, act, it.exp);
        end
      end
    end
  end

  task automatic run_case(input string req, input bit md, input logic [7:0] s,
                          input bit flip_mode, input logic [7:0] e0, input logic [7:0] e1);
    rst_n  = 1'b0;
    mode_i = md;
    sw_i   = s;
    repeat (3) @(negedge clk);
    expect_val("R1 reset display", 0, 8'h00);
    expect_val("R1 reset display", 1, 8'h00);
    sample();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    if (flip_mode) mode_i = ~md;
    repeat (300) @(negedge clk);
    expect_val(req, 0, e0);
    expect_val(req, 1, e1);
    sample();
    sw_i = ~s;
    repeat (12) @(negedge clk);
    expect_val("R7 frozen after finish", 0, e0);
    expect_val("R7 frozen after finish", 1, e1);
    sample();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] par;
    logic [7:0] syn;
    logic [7:0] s100;
    logic [7:0] nm;
    bit         found;

    par = model(MSG, 1'b1, 8'h00);
    syn = 8'h01;
    for (int k = 0; k < 255 - ERR_POS; k++) syn = {syn[6:0], 1'b0} ^ (syn[7] ? POLY : 8'h00);

    // R2: parity with switches at zero
    run_case("R2 parity", 1'b1, 8'h00, 1'b0, par, model(MSG_ERR, 1'b1, 8'h00));

    // R3 on the clean message, R9 syndrome on the corrupted one
    run_case("R3/R9 check with parity", 1'b1, par, 1'b0, 8'h00, syn);
    checks++;
    if (syn == 8'h00) begin
      errors++;
      $display("FAIL R9: syndrome=%h expected nonzero", syn);
    end

    // R4: tail bits taken from switches, bit 7 first
    run_case("R4 switch tail", 1'b1, 8'hA5, 1'b0, model(MSG, 1'b1, 8'hA5), model(MSG_ERR, 1'b1, 8'hA5));

    // R5: zero pattern matches at once
    run_case("R5 immediate match", 1'b0, 8'h00, 1'b0, 8'h00, 8'h00);

    // R5: match somewhere within the run
    s100 = state_after(MSG, 100);
    run_case("R5 match position", 1'b0, s100, 1'b0, model(MSG, 1'b0, s100), model(MSG_ERR, 1'b0, s100));

    // R5: locating with the syndrome on the switches
    run_case("R5 locate syndrome", 1'b0, syn, 1'b0, model(MSG, 1'b0, syn), model(MSG_ERR, 1'b0, syn));

    // R6: pattern never reached
    found = 1'b0;
    nm    = 8'h00;
    for (int v = 1; v < 256; v++) begin
      if (!found && never_hits(MSG, 8'(v)) && never_hits(MSG_ERR, 8'(v))) begin
        found = 1'b1;
        nm    = 8'(v);
      end
    end
    if (found) run_case("R6 no match", 1'b0, nm, 1'b0, 8'hFF, 8'hFF);

    // R8: mode input flipped during the run is ignored
    run_case("R8 mode held (locate)", 1'b0, s100, 1'b1, model(MSG, 1'b0, s100), model(MSG_ERR, 1'b0, s100));
    run_case("R8 mode held (parity)", 1'b1, 8'h00, 1'b1, par, model(MSG_ERR, 1'b1, 8'h00));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule